// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block follows a processor core through its power-saving states and drives the enables that each state allows. It runs on an always-on reference clock, so it keeps counting and deciding while the bus clock is stopped. A stop-grant request, a halt indication, an active-low sleep request and a bus-clock-running flag move it between the states. The block reports the current state as a 3-bit code. It also gives enables for the internal cache clock, snoop acceptance and interrupt latching, a flag that says the interrupt controller clock may be stopped, and a sticky flag for bus protocol violations.

The deepest state is entered only when the bus clock stops while the core is already in Sleep. It is left only when that clock runs again. After a restart, a PLL relock wait of `RELOCK_CYC` reference cycles must finish before Sleep is reported again and the cache clock comes back. The sleep request and the clock-running flag are asynchronous. Each passes through a two-flop synchronizer before the state logic uses it. All pins are plain control and status levels, so the block has no streaming interface and no back-pressure.

Top module: `pwr_state_seq`

## Requirements
- R1: After reset the state is Normal (code 0). Cache clock, snoop and interrupt latch enables are high. The clock-may-stop and violation flags are low.
- R2: The state codes are Normal=0, AutoHALT=1, Stop-Grant=2, Sleep=3, Deep Sleep=4 and Relock-wait=5. Normal and AutoHALT follow the halt indication. A stop-grant request moves either of them to Stop-Grant. Dropping the request in Stop-Grant while the sleep request is inactive returns the block to Normal.
- R3: Stop-Grant goes to Sleep only after the synchronized sleep request has been seen asserted for `SLP_QUAL` consecutive reference cycles. A shorter pulse is ignored.
- R4: Deep Sleep is entered only from Sleep or Relock-wait, as soon as the synchronized clock-running flag is low. In Sleep this takes priority over the sleep request.
- R5: When the clock restarts in Deep Sleep, the block goes to Relock-wait. It then reports Sleep on exactly the `RELOCK_CYC`-th edge after it entered Relock-wait.
- R6: If the clock stops during Relock-wait, the block returns to Deep Sleep. The next relock wait starts again from zero.
- R7: In Sleep with the clock running, deasserting the sleep request (input high) returns the block to Stop-Grant.
- R8: Snoop enable and interrupt latch enable are high only in states 0, 1 and 2.
- R9: The cache clock enable is low in Deep Sleep and Relock-wait and high in every other state.
- R10: The interrupt-clock-may-stop flag is high only in states 3, 4 and 5.
- R11: The violation flag sets one cycle after a bus strobe, or a change on the stop-grant request or halt inputs, is seen in state 4 or 5. It stays set until reset. The same activity in other states has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stpgnt_req | input | 1 | Stop-grant request |
| sleep_req_n | input | 1 | Asynchronous sleep request, active low |
| halt_ind | input | 1 | Core has halted |
| bclk_run | input | 1 | Asynchronous flag, bus clock is running |
| bus_strobe | input | 1 | Bus activity strobe |
| pwr_state | output | 3 | Encoded power state |
| cache_clk_en | output | 1 | Internal cache clock enable |
| snoop_en | output | 1 | Snoops are accepted |
| intr_latch_en | output | 1 | Interrupts are latched |
| intclk_stop_ok | output | 1 | Interrupt controller clock may stop |
| proto_viol | output | 1 | Sticky bus protocol violation |

## Verification
The assertions check on every cycle that the state code is legal and that Deep Sleep is reached only from Sleep or Relock-wait. They also check that Sleep is reached only from Stop-Grant or Relock-wait, that the relock counter stays in range, and that a set violation flag never clears. Only the bench scenarios can show the timing and the effect of the inputs. These scenarios cover the exact relock length and its restart after a second clock stop, a too-short sleep pulse being ignored, and bus activity setting the flag in Deep Sleep but not in Normal.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL   = 3'd0,
    ST_AUTOHALT = 3'd1,
    ST_STOPGNT  = 3'd2,
    ST_SLEEP    = 3'd3,
    ST_DEEP     = 3'd4,
    ST_RELOCK   = 3'd5
  } pwr_state_e;
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/pss_relock_timer.sv
module pss_relock_timer #(
  parameter int RELOCK_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(RELOCK_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RELOCK_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run)          cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_cnt_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/pss_viol_mon.sv
module pss_viol_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic quiet_win,
  input  logic bus_strobe,
  input  logic stpgnt_req,
  input  logic halt_ind,
  output logic viol
);
  logic stp_prev_q, halt_prev_q, viol_q;
  logic activity;

  always_comb begin
    activity = bus_strobe || (stpgnt_req != stp_prev_q) || (halt_ind != halt_prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stp_prev_q  <= 1'b0;
      halt_prev_q <= 1'b0;
      viol_q      <= 1'b0;
    end else begin
      stp_prev_q  <= stpgnt_req;
      halt_prev_q <= halt_ind;
      if (quiet_win && activity) viol_q <= 1'b1;
    end
  end

  assign viol = viol_q;

  assert_viol_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |=> viol_q);
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
  import pss_pkg::*;
#(
  parameter int SLP_QUAL = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stpgnt_req,
  input  logic       halt_ind,
  input  logic       slp_act,
  input  logic       clk_run,
  input  logic       relock_done,
  output pwr_state_e state_o
);
  localparam int QW = $clog2(SLP_QUAL + 1);
  localparam logic [QW-1:0] QLAST = QW'(SLP_QUAL - 1);

  pwr_state_e state_q, state_d;
  logic [QW-1:0] qual_q;
  logic slp_ok;

  assign slp_ok = slp_act && (qual_q == QLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      qual_q <= '0;
    else if (state_q == ST_STOPGNT && slp_act) begin
      if (qual_q != QLAST)                           qual_q <= qual_q + 1'b1;
    end else                                         qual_q <= '0;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL:   if (stpgnt_req) state_d = ST_STOPGNT;
                   else if (halt_ind) state_d = ST_AUTOHALT;
      ST_AUTOHALT: if (stpgnt_req) state_d = ST_STOPGNT;
                   else if (!halt_ind) state_d = ST_NORMAL;
      ST_STOPGNT:  if (slp_ok) state_d = ST_SLEEP;
                   else if (!stpgnt_req && !slp_act) state_d = ST_NORMAL;
      ST_SLEEP:    if (!clk_run) state_d = ST_DEEP;
                   else if (!slp_act) state_d = ST_STOPGNT;
      ST_DEEP:     if (clk_run) state_d = ST_RELOCK;
      ST_RELOCK:   if (!clk_run) state_d = ST_DEEP;
                   else if (relock_done) state_d = ST_SLEEP;
      default:     state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_NORMAL;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  assert_legal_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q <= ST_RELOCK);
  assert_deep_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_DEEP) |=> (state_q != ST_DEEP) || $past(state_q) == ST_SLEEP || $past(state_q) == ST_RELOCK);
  assert_sleep_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_SLEEP) |=> (state_q != ST_SLEEP) || $past(state_q) == ST_STOPGNT || $past(state_q) == ST_RELOCK);
  assert_relock_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RELOCK && clk_run && relock_done) |=> state_q == ST_SLEEP);
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pss_pkg::*;
#(
  parameter int RELOCK_CYC = 50000,
  parameter int SLP_QUAL   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stpgnt_req,
  input  logic       sleep_req_n,
  input  logic       halt_ind,
  input  logic       bclk_run,
  input  logic       bus_strobe,
  output logic [2:0] pwr_state,
  output logic       cache_clk_en,
  output logic       snoop_en,
  output logic       intr_latch_en,
  output logic       intclk_stop_ok,
  output logic       proto_viol
);
  logic [1:0] sync_out;
  logic slp_act, clk_run, relock_done, quiet_win;
  pwr_state_e st;

  pss_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({sleep_req_n, bclk_run}),
    .q_sync(sync_out)
  );

  assign slp_act = !sync_out[1];
  assign clk_run = sync_out[0];

  pss_relock_timer #(.RELOCK_CYC(RELOCK_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .run(st == ST_RELOCK),
    .done(relock_done)
  );

  pss_fsm #(.SLP_QUAL(SLP_QUAL)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .stpgnt_req(stpgnt_req), .halt_ind(halt_ind),
    .slp_act(slp_act), .clk_run(clk_run),
    .relock_done(relock_done),
    .state_o(st)
  );

  assign quiet_win = (st == ST_DEEP) || (st == ST_RELOCK);

  pss_viol_mon u_viol (
    .clk(clk), .rst_n(rst_n),
    .quiet_win(quiet_win), .bus_strobe(bus_strobe),
    .stpgnt_req(stpgnt_req), .halt_ind(halt_ind),
    .viol(proto_viol)
  );

  always_comb begin
    pwr_state      = st;
    cache_clk_en   = !quiet_win;
    snoop_en       = (st == ST_NORMAL) || (st == ST_AUTOHALT) || (st == ST_STOPGNT);
    intr_latch_en  = snoop_en;
    intclk_stop_ok = (st == ST_SLEEP) || quiet_win;
  end
endmodule

// File: tb/tb_pwr_state_seq.sv
module tb_pwr_state_seq;
  localparam int RCYC = 40;
  localparam int QUAL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stpgnt_req = 1'b0, sleep_req_n = 1'b1, halt_ind = 1'b0;
  logic bclk_run = 1'b1, bus_strobe = 1'b0;
  logic [2:0] pwr_state;
  logic cache_clk_en, snoop_en, intr_latch_en, intclk_stop_ok, proto_viol;

  int n_checks = 0;
  int n_fails = 0;

  typedef struct {
    logic [2:0] st;
    logic       viol;
    string      tag;
  } exp_t;
  exp_t exp_q[$];
  event chk_ev;

  always #10 clk = ~clk;

  pwr_state_seq #(.RELOCK_CYC(RCYC), .SLP_QUAL(QUAL)) dut (
    .clk(clk), .rst_n(rst_n), .stpgnt_req(stpgnt_req), .sleep_req_n(sleep_req_n),
    .halt_ind(halt_ind), .bclk_run(bclk_run), .bus_strobe(bus_strobe),
    .pwr_state(pwr_state), .cache_clk_en(cache_clk_en), .snoop_en(snoop_en),
    .intr_latch_en(intr_latch_en), .intclk_stop_ok(intclk_stop_ok), .proto_viol(proto_viol)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input logic [2:0] st, input logic viol, input string tag);
    exp_t e;
    e.st = st; e.viol = viol; e.tag = tag;
    exp_q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      exp_t e;
      logic en_exp, stop_exp, cce_exp;
      @(chk_ev);
      e = exp_q.pop_front();
      en_exp   = (e.st <= 3'd2);
      stop_exp = (e.st >= 3'd3);
      cce_exp  = !(e.st == 3'd4 || e.st == 3'd5);
      cmp(e.tag, "state", pwr_state, e.st);
      cmp({e.tag, "/R8"}, "snoop_en", snoop_en, en_exp);
      cmp({e.tag, "/R8"}, "intr_latch_en", intr_latch_en, en_exp);
      cmp({e.tag, "/R9"}, "cache_clk_en", cache_clk_en, cce_exp);
      cmp({e.tag, "/R10"}, "intclk_stop_ok", intclk_stop_ok, stop_exp);
      cmp({e.tag, "/R11"}, "proto_viol", proto_viol, e.viol);
    end
  end

  initial begin
    #(20 * 200000);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    expect_now(3'd0, 1'b0, "R1 reset");

    halt_ind = 1'b1; cyc(2);
    expect_now(3'd1, 1'b0, "R2 autohalt");
    halt_ind = 1'b0; cyc(2);
    expect_now(3'd0, 1'b0, "R2 back to normal");

    bus_strobe = 1'b1; cyc(1); bus_strobe = 1'b0; cyc(2);
    expect_now(3'd0, 1'b0, "R11 strobe in normal ignored");

    halt_ind = 1'b1; cyc(2);
    stpgnt_req = 1'b1; cyc(2);
    expect_now(3'd2, 1'b0, "R2 stop-grant from autohalt");
    halt_ind = 1'b0; cyc(2);

    sleep_req_n = 1'b0; cyc(1); sleep_req_n = 1'b1; cyc(8);
    expect_now(3'd2, 1'b0, "R3 short sleep pulse ignored");

    sleep_req_n = 1'b0; cyc(10);
    expect_now(3'd3, 1'b0, "R3 sleep entered");

    bclk_run = 1'b0; cyc(4);
    expect_now(3'd4, 1'b0, "R4 deep sleep");

    bclk_run = 1'b1; cyc(2 + RCYC);
    expect_now(3'd5, 1'b0, "R5 still relocking");
    cyc(1);
    expect_now(3'd3, 1'b0, "R5 sleep after relock");

    bclk_run = 1'b0; cyc(4);
    expect_now(3'd4, 1'b0, "R4 deep again");
    bclk_run = 1'b1; cyc(20);
    expect_now(3'd5, 1'b0, "R6 mid relock");
    bclk_run = 1'b0; cyc(4);
    expect_now(3'd4, 1'b0, "R6 back to deep");
    bclk_run = 1'b1; cyc(2 + RCYC);
    expect_now(3'd5, 1'b0, "R6 full wait restarted");
    cyc(1);
    expect_now(3'd3, 1'b0, "R6 sleep after full wait");

    sleep_req_n = 1'b1; cyc(5);
    expect_now(3'd2, 1'b0, "R7 sleep exit");
    stpgnt_req = 1'b0; cyc(5);
    expect_now(3'd0, 1'b0, "R2 stop-grant released");

    stpgnt_req = 1'b1; cyc(3);
    sleep_req_n = 1'b0; cyc(10);
    bclk_run = 1'b0; cyc(4);
    expect_now(3'd4, 1'b0, "R11 deep before strobe");
    bus_strobe = 1'b1; cyc(1); bus_strobe = 1'b0; cyc(1);
    expect_now(3'd4, 1'b1, "R11 strobe in deep flagged");
    bclk_run = 1'b1; cyc(3 + RCYC);
    expect_now(3'd3, 1'b1, "R11 flag held");
    sleep_req_n = 1'b1; cyc(5);
    stpgnt_req = 1'b0; cyc(5);
    expect_now(3'd0, 1'b1, "R11 flag sticky in normal");

    cyc(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule